// File: doc/BRIEF.md
# Addressable Control Latch with Vertical-Blank NMI

This block holds eight single-bit system controls that a CPU sets or clears through a 16-byte write window on its bus. The three lowest address bits choose which control bit is written and the next address bit carries the value to store. The data bus plays no part, so one bit changes on each write. Bit 0 hands a shared RAM to the main CPU or to the sub CPU. Bit 1 enables the non-maskable interrupt. Bit 4 drives a halt/run line for a companion microcontroller. The other bits are stored and shown on the latch output only.

The same block raises the NMI on each vertical blank. A small state machine has three states. NMI_OFF means interrupts are disabled. NMI_ARMED means they are enabled and nothing is pending. NMI_FIRED means the interrupt line is asserted. Its transitions are:
- T_ENABLE: a write to offset 0x9 moves NMI_OFF to NMI_ARMED.
- T_FIRE: a rising edge of vertical blank while enabled moves to NMI_FIRED.
- T_DISABLE: a write to offset 0x1 returns any state to NMI_OFF.

NMI_FIRED holds until T_DISABLE. A single NMI output is meant to be wired to both CPUs at once.

Top module: `ctl_latch_nmi`

## Requirements
- R1: A write strobe with the address inside the window (base 0x4800, 16 bytes) stores address bit 3 into the latch bit numbered by address bits 2:0. All other latch bits keep their values. The result is visible from the clock edge that samples the strobe.
- R2: A strobe with the address outside the window changes no latch bit and no NMI state. The value on the data bus has no effect on any write.
- R3: After reset all latch bits are 0, the NMI output is low, the shared RAM belongs to the sub CPU, and the halt/run output is 0.
- R4: The RAM owner output equals latch bit 0, where 1 means the main CPU and 0 means the sub CPU. A write to offset 0x8 gives ownership to the main CPU and a write to offset 0x0 gives it to the sub CPU.
- R5: A write to offset 0x1 clears latch bit 1, disabling NMI, and drops the NMI output on the same edge.
- R6: A write to offset 0x9 sets latch bit 1. While that bit is 1, a rising edge of vertical blank asserts NMI from the edge that samples the high level. NMI then stays high through the end of vertical blank and through later edges until a write to offset 0x1.
- R7: A vertical-blank rising edge while NMI is disabled is not remembered, so enabling NMI afterwards does not assert it.
- R8: Only rising edges of vertical blank count. If NMI is disabled and then re-enabled while vertical blank stays high, NMI stays low until the next rising edge.
- R9: The halt/run output follows latch bit 4, set by offset 0xC and cleared by offset 0x4. Bits 2, 3, 5, 6 and 7 appear only on the latch output.
- R10: In the cycle of a rising edge of vertical blank, an enable write in the same cycle lets NMI fire, while a disable write in the same cycle keeps it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | CPU write address |
| bus_data | input | 8 | CPU write data (not used by the latch) |
| bus_wr | input | 1 | One-cycle write strobe |
| vblank | input | 1 | Vertical blank level, synchronous to clk |
| latch_q | output | 8 | All eight control bits |
| ram_owner_main | output | 1 | 1: main CPU owns the shared RAM, 0: sub CPU |
| mcu_run | output | 1 | Microcontroller halt/run control |
| nmi | output | 1 | Interrupt line shared by both CPUs |

## Verification
Every latch result and every NMI change is due at the first clock edge that samples the strobe or the vertical-blank level. No pipeline stage sits between the inputs and the outputs. The bench drives inputs on the falling edge and checks outputs on the next falling edge, which is half a cycle after the edge that must have updated them. For R8 and R7 the bench checks over several following cycles that NMI stays low, and then checks that it rises on exactly the one edge after vertical blank goes high again.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
    typedef enum logic [1:0] {
        NMI_OFF   = 2'd0,
        NMI_ARMED = 2'd1,
        NMI_FIRED = 2'd2
    } nmi_state_e;
endpackage

// File: rtl/ctl_win_decode.sv
module ctl_win_decode #(
    parameter int          ADDR_W = 16,
    parameter int          NBITS  = 8,
    parameter logic [15:0] BASE   = 16'h4800
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output logic [NBITS-1:0]  strobe,
    output logic              value
);
    localparam int SEL_W = $clog2(NBITS);
    localparam int WIN_W = SEL_W + 1;

    logic hit;
    logic [SEL_W-1:0] sel;

    always_comb begin
        hit   = wr && (addr[ADDR_W-1:WIN_W] == BASE[ADDR_W-1:WIN_W]);
        sel   = addr[SEL_W-1:0];
        value = addr[SEL_W];
    end

    for (genvar i = 0; i < NBITS; i++) begin : g_strobe
        assign strobe[i] = hit && (sel == SEL_W'(i));
    end
endmodule

// File: rtl/ctl_bit_bank.sv
module ctl_bit_bank #(
    parameter int NBITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] strobe,
    input  logic             value,
    output logic [NBITS-1:0] q
);
    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= 1'b0;
            else if (strobe[i])
                q[i] <= value;
        end
    end
endmodule

// File: rtl/ctl_edge_det.sv
module ctl_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic level_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            level_q <= 1'b0;
        else
            level_q <= level;
    end

    assign rise = level && !level_q;
endmodule

// File: rtl/ctl_nmi_fsm.sv
module ctl_nmi_fsm
    import ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_set,
    input  logic en_clr,
    input  logic edge_in,
    output logic nmi
);
    nmi_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= NMI_OFF;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NMI_OFF: begin
                if (en_set && edge_in)
                    state_d = NMI_FIRED;
                else if (en_set)
                    state_d = NMI_ARMED;
            end
            NMI_ARMED: begin
                if (en_clr)
                    state_d = NMI_OFF;
                else if (edge_in)
                    state_d = NMI_FIRED;
            end
            NMI_FIRED: begin
                if (en_clr)
                    state_d = NMI_OFF;
            end
            default: state_d = NMI_OFF;
        endcase
    end

    always_comb begin
        nmi = (state_q == NMI_FIRED);
    end
endmodule

// File: rtl/ctl_latch_nmi.sv
module ctl_latch_nmi #(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 8,
    parameter int          NBITS     = 8,
    parameter logic [15:0] BASE      = 16'h4800,
    parameter int          OWNER_BIT = 0,
    parameter int          NMI_BIT   = 1,
    parameter int          MCU_BIT   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_wr,
    input  logic              vblank,
    output logic [NBITS-1:0]  latch_q,
    output logic              ram_owner_main,
    output logic              mcu_run,
    output logic              nmi
);
    logic [NBITS-1:0] strobe;
    logic             value;
    logic             vb_rise;
    logic             data_unused;

    assign data_unused = ^bus_data;

    ctl_win_decode #(.ADDR_W(ADDR_W), .NBITS(NBITS), .BASE(BASE)) u_dec (
        .addr(bus_addr), .wr(bus_wr), .strobe(strobe), .value(value)
    );

    ctl_bit_bank #(.NBITS(NBITS)) u_bank (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .value(value), .q(latch_q)
    );

    ctl_edge_det u_edge (
        .clk(clk), .rst_n(rst_n), .level(vblank), .rise(vb_rise)
    );

    ctl_nmi_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .en_set(strobe[NMI_BIT] && value),
        .en_clr(strobe[NMI_BIT] && !value),
        .edge_in(vb_rise), .nmi(nmi)
    );

    assign ram_owner_main = latch_q[OWNER_BIT];
    assign mcu_run        = latch_q[MCU_BIT];
endmodule

// File: rtl/ctl_latch_nmi_chk.sv
module ctl_latch_nmi_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] bus_addr,
    input logic        bus_wr,
    input logic [7:0]  latch_q,
    input logic        nmi
);
    logic in_win;
    assign in_win = bus_wr && (bus_addr[15:4] == 12'h480);

    AST_WRITE_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        in_win |=> latch_q[$past(bus_addr[2:0])] == $past(bus_addr[3])); // R1
    AST_OUTSIDE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_win |=> $stable(latch_q)); // R2
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_win && bus_addr[3:0] == 4'h1) |=> !nmi); // R5
    AST_NMI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi && !(in_win && bus_addr[3:0] == 4'h1)) |=> nmi); // R6
    AST_NMI_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        nmi |-> latch_q[1]); // R7
endmodule

bind ctl_latch_nmi ctl_latch_nmi_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .latch_q(latch_q), .nmi(nmi)
);

// File: tb/ctl_latch_nmi_tb.sv
module ctl_latch_nmi_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_data = '0;
    logic        bus_wr = 1'b0;
    logic        vblank = 1'b0;
    logic [7:0]  latch_q;
    logic        ram_owner_main, mcu_run, nmi;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_q = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctl_latch_nmi u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_wr(bus_wr), .vblank(vblank), .latch_q(latch_q),
        .ram_owner_main(ram_owner_main), .mcu_run(mcu_run), .nmi(nmi)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        bus_addr = a; bus_data = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0;
        if (a[15:4] == 12'h480) exp_q[a[2:0]] = a[3];
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3 latch", latch_q, 8'h00);
        chk("R3 nmi", nmi, 0);
        chk("R3 owner", ram_owner_main, 0);
        chk("R3 mcu", mcu_run, 0);

        // R1/R2 sweep: every offset with several data values
        for (int pass = 0; pass < 3; pass++) begin
            for (int off = 0; off < 16; off++) begin
                int o = (pass == 1) ? 15 - off : off;
                wr(16'h4800 + 16'(o), 8'((o * 37 + pass * 91) & 8'hff));
                chk("R1 sweep", latch_q, exp_q);
                chk("R4 owner", ram_owner_main, exp_q[0]);
                chk("R9 mcu", mcu_run, exp_q[4]);
            end
        end
        // R2: outside addresses
        for (int k = 0; k < 12; k++) begin
            logic [15:0] a;
            a = (k < 6) ? 16'h4810 + 16'(k * 3) : 16'h47F0 + 16'(k);
            if (k == 11) a = 16'hC808;
            wr(a, 8'hFF);
            chk("R2 outside", latch_q, exp_q);
        end
        // R4 explicit
        wr(16'h4808, 8'h00); chk("R4 main", ram_owner_main, 1);
        wr(16'h4800, 8'hFF); chk("R4 sub", ram_owner_main, 0);
        // R9 explicit
        wr(16'h480C, 8'h00); chk("R9 run set", mcu_run, 1);
        wr(16'h4804, 8'h00); chk("R9 run clr", mcu_run, 0);

        // R7: edge while disabled not remembered
        wr(16'h4801, 8'h00);
        vblank = 1'b1; step(); chk("R7 disabled edge", nmi, 0);
        vblank = 1'b0; step();
        wr(16'h4809, 8'h00); chk("R7 enable no stored", nmi, 0);
        step(); chk("R7 still low", nmi, 0);

        // R6: fire and hold
        vblank = 1'b1; step(); chk("R6 fire", nmi, 1);
        vblank = 1'b0; step(); chk("R6 hold after vblank", nmi, 1);
        vblank = 1'b1; step(); vblank = 1'b0; step(); chk("R6 hold second edge", nmi, 1);
        wr(16'h4802, 8'h00); chk("R6 other write holds", nmi, 1);
        // R5: disable clears at once
        vblank = 1'b1;
        wr(16'h4801, 8'h00); chk("R5 clear", nmi, 0);
        chk("R5 bit1", latch_q[1], 0);
        // R8: vblank still high, re-enable gives nothing
        wr(16'h4809, 8'h00); chk("R8 no level fire", nmi, 0);
        repeat (3) step();
        chk("R8 still low", nmi, 0);
        vblank = 1'b0; step(); chk("R8 low", nmi, 0);
        vblank = 1'b1; step(); chk("R8 next edge", nmi, 1);
        vblank = 1'b0;
        wr(16'h4801, 8'h00);

        // R10: same-cycle enable + edge fires
        step();
        vblank = 1'b1;
        wr(16'h4809, 8'h00); chk("R10 enable+edge", nmi, 1);
        vblank = 1'b0; step();
        // R10: same-cycle disable + edge stays low (start armed, not fired)
        wr(16'h4801, 8'h00);
        wr(16'h4809, 8'h00); chk("R10 armed", nmi, 0);
        vblank = 1'b1;
        wr(16'h4801, 8'h00); chk("R10 disable+edge", nmi, 0);
        step(); chk("R10 stays low", nmi, 0);
        vblank = 1'b0;
        chk("R1 final latch", latch_q, exp_q);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule